// File: doc/BRIEF.md
# Scanline Interrupt and Status Sequencer

This block produces the per-frame interrupt and status timing of a video display processor. The host CPU's cycle tick drives it. It divides each frame into scanlines of a fixed number of cycles. A short active-scan lead-in comes before the first line. The frame is split into visible lines, one vertical-interrupt line and blanking lines. Line counts depend on a 50/60 Hz select and a 240-line select, and both are captured at each frame start.

On every visible line, and once more on the vertical-interrupt line, a horizontal-interrupt down-counter steps. When it passes zero it reloads from a register value and marks a pending horizontal interrupt. On the vertical-interrupt line the vblank status bit and a pending vertical interrupt are set. The vertical request becomes visible a fixed number of cycles later, and the rest of that line is shortened so the frame length stays the same. A write-FIFO model raises an empty flag as each visible line drains it. CPU write pulses fill it again.

Pending bits are held until acknowledged. The two interrupt request outputs combine the pending bits with the enable inputs.

Top module: `seq_scanline_irq`

## Requirements
- R1: Only cycles with `cyc_tick` high advance timing. After reset or a frame start, visible line 0 begins after LEAD_CYC ticks, and each later line begins LINE_CYC ticks after the one before it (defaults 148 and 488).
- R2: At frame start, status bits 7 and 3 clear and the horizontal counter reloads from `hint_reload`.
- R3: At the start of every visible line and of the vertical-interrupt line, the horizontal counter steps down by one. A step taken when it holds 0 instead reloads it from `hint_reload` and sets pending bit 4 (`pend_bits[4]`). Blanking lines do not step it.
- R4: `irq_lvl4` is high exactly when pending bit 4 is set and `hint_en` is high.
- R5: At the start of the vertical-interrupt line (the line right after the last visible line), status bit 3 (vblank) and pending bit 5 are set.
- R6: LAG_CYC ticks after the vertical-interrupt line starts (default 68), status bit 7 sets. `irq_lvl6` is high exactly when pending bit 5, status bit 7 and `vint_en` are all high.
- R7: The vertical-interrupt line lasts LINE_CYC minus LEAD_CYC ticks in total, so one frame lasts total-lines × LINE_CYC ticks.
- R8: At each visible line start, a write counter drops by FIFO_DRAIN (12). If it held FIFO_DRAIN or less, it becomes 0 and status bit 9 (FIFO empty) sets.
- R9: At the vertical-interrupt line start, the write counter clears and status bit 9 sets.
- R10: A `fifo_wr` pulse adds one to the write counter, saturating at its maximum, and clears status bit 9. It is applied after any line event in the same cycle.
- R11: `ack_hint` clears pending bit 4 and `ack_vint` clears pending bit 5. A set in the same cycle wins.
- R12: With `pal_sel` low there are NTSC_LINES lines, NTSC_VIS of them visible. With `pal_sel` high there are PAL_LINES lines with PAL_VIS visible, or PAL_TALL_VIS visible when `tall_sel` is also high. Both selects are sampled at reset and at each frame start.
- R13: During reset, `pend_bits` is 0, `status_word` is 0x0200, and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One CPU cycle elapsed |
| pal_sel | input | 1 | 50 Hz line-count select |
| tall_sel | input | 1 | 240-line select (50 Hz only) |
| hint_reload | input | HINT_W | Horizontal counter reload value |
| hint_en | input | 1 | Level-4 request enable |
| vint_en | input | 1 | Level-6 request enable |
| fifo_wr | input | 1 | CPU write into the FIFO |
| ack_hint | input | 1 | Clear pending bit 4 |
| ack_vint | input | 1 | Clear pending bit 5 |
| pend_bits | output | 8 | Pending interrupts (bit 4 horizontal, bit 5 vertical) |
| status_word | output | 16 | Status (bit 9 FIFO empty, bit 7 vertical flag, bit 3 vblank) |
| irq_lvl4 | output | 1 | Horizontal interrupt request |
| irq_lvl6 | output | 1 | Vertical interrupt request |

## Verification
The hardest state to reach is write-counter saturation right before a visible line drains it. The counter must then stay non-empty for exactly one more line. The bench reaches this with a directed burst of writes while `cyc_tick` is held low, then lets ticks resume. The other hard cases are mode changes that land mid-frame and must wait for the next frame start, and an acknowledge that coincides with an underflow. Random toggling of the selects and acknowledges, with ticks gated, produces both of these against a position-in-frame model.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [1:0] {PH_LEAD, PH_LINE, PH_LAG, PH_TAIL} phase_t;
   typedef struct packed {
      logic frame;
      logic vis;
      logic vline;
      logic fire;
   } evt_t;
endpackage

// File: rtl/seq_frame_timer.sv
module seq_frame_timer
   import seq_pkg::*;
#(
   parameter int LINE_CYC     = 488,
   parameter int LEAD_CYC     = 148,
   parameter int LAG_CYC      = 68,
   parameter int NTSC_LINES   = 262,
   parameter int NTSC_VIS     = 224,
   parameter int PAL_LINES    = 313,
   parameter int PAL_VIS      = 224,
   parameter int PAL_TALL_VIS = 240,
   parameter bit TALL_EN      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pal_sel,
   input  logic tall_sel,
   output evt_t evt
);
   localparam int TAIL_CYC = LINE_CYC - LAG_CYC - LEAD_CYC;
   localparam int CYC_W    = $clog2(LINE_CYC);
   localparam int MAXL     = (NTSC_LINES > PAL_LINES) ? NTSC_LINES : PAL_LINES;
   localparam int LN_W     = $clog2(MAXL + 1);

   generate
      if (TAIL_CYC < 1) begin : g_bad_split
         $error("lead plus lag must be shorter than one line");
      end
      if (NTSC_VIS >= NTSC_LINES || PAL_VIS >= PAL_LINES || PAL_TALL_VIS >= PAL_LINES) begin : g_bad_lines
         $error("visible lines must be fewer than total lines");
      end
      if (NTSC_VIS < 1 || PAL_VIS < 1 || PAL_TALL_VIS < 1) begin : g_bad_vis
         $error("at least one visible line is needed");
      end
   endgenerate

   logic tall_in;
   generate
      if (TALL_EN) begin : g_tall
         assign tall_in = tall_sel;
      end else begin : g_no_tall
         assign tall_in = 1'b0;
      end
   endgenerate

   phase_t           phase;
   logic [CYC_W-1:0] cyc;
   logic [LN_W-1:0]  line;
   logic             mode_pal, mode_tall;
   logic [LN_W-1:0]  vis_n, tot_n, nxt_line;
   logic [CYC_W-1:0] seg_last;
   logic             seg_end;

   always_comb begin
      vis_n    = mode_pal ? (mode_tall ? LN_W'(PAL_TALL_VIS) : LN_W'(PAL_VIS)) : LN_W'(NTSC_VIS);
      tot_n    = mode_pal ? LN_W'(PAL_LINES) : LN_W'(NTSC_LINES);
      nxt_line = line + 1'b1;
      case (phase)
         PH_LEAD: seg_last = CYC_W'(LEAD_CYC - 1);
         PH_LAG:  seg_last = CYC_W'(LAG_CYC - 1);
         PH_TAIL: seg_last = CYC_W'(TAIL_CYC - 1);
         default: seg_last = CYC_W'(LINE_CYC - 1);
      endcase
      seg_end = tick && (cyc == seg_last);
   end

   always_comb begin
      evt = '0;
      if (seg_end) begin
         case (phase)
            PH_LEAD: evt.vis = 1'b1;
            PH_LINE: begin
               if (nxt_line == tot_n)     evt.frame = 1'b1;
               else if (nxt_line < vis_n) evt.vis   = 1'b1;
               else if (nxt_line == vis_n) evt.vline = 1'b1;
            end
            PH_LAG:  evt.fire = 1'b1;
            default: evt.frame = (nxt_line == tot_n);
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_LEAD;
         cyc       <= '0;
         line      <= '0;
         mode_pal  <= pal_sel;
         mode_tall <= tall_in;
      end else if (tick) begin
         if (seg_end) begin
            cyc <= '0;
            if (evt.frame) begin
               phase     <= PH_LEAD;
               line      <= '0;
               mode_pal  <= pal_sel;
               mode_tall <= tall_in;
            end else begin
               case (phase)
                  PH_LEAD: begin
                     phase <= PH_LINE;
                     line  <= '0;
                  end
                  PH_LINE: begin
                     line <= nxt_line;
                     if (evt.vline) phase <= PH_LAG;
                  end
                  PH_LAG:  phase <= PH_TAIL;
                  default: begin
                     phase <= PH_LINE;
                     line  <= nxt_line;
                  end
               endcase
            end
         end else begin
            cyc <= cyc + 1'b1;
         end
      end
   end

   // R7
   evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt.frame, evt.vis, evt.vline, evt.fire}));

   // R1
   evt_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> (evt == '0));
endmodule

// File: rtl/seq_hint_ctr.sv
module seq_hint_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_ev,
   input  logic             line_ev,
   input  logic [CNT_W-1:0] reload,
   input  logic             ack,
   output logic             pend
);
   logic [CNT_W-1:0] cnt;
   logic             set_now;

   assign set_now = line_ev && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= reload;
         pend <= 1'b0;
      end else begin
         if (frame_ev || set_now) cnt <= reload;
         else if (line_ev)        cnt <= cnt - 1'b1;
         pend <= set_now || (pend && !ack);
      end
   end

   // R3
   hint_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(line_ev));

   // R11
   hint_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !line_ev) |=> !pend);
endmodule

// File: rtl/seq_fifo_flag.sv
module seq_fifo_flag #(
   parameter int CNT_W = 6,
   parameter int DRAIN = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_ev,
   input  logic vline_ev,
   input  logic wr,
   output logic empty
);
   localparam logic [CNT_W-1:0] DRAIN_V = CNT_W'(DRAIN);

   generate
      if (DRAIN < 1 || DRAIN >= (1 << CNT_W)) begin : g_bad_drain
         $error("drain amount must fit the write counter");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, after_ev;
   logic             drained;

   always_comb begin
      drained  = (line_ev && (cnt <= DRAIN_V)) || vline_ev;
      after_ev = cnt;
      if (drained)      after_ev = '0;
      else if (line_ev) after_ev = cnt - DRAIN_V;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         empty <= 1'b1;
      end else begin
         cnt <= (wr && (after_ev != '1)) ? after_ev + 1'b1 : after_ev;
         if (wr)           empty <= 1'b0;
         else if (drained) empty <= 1'b1;
      end
   end

   // R10
   fifo_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !empty);

   // R9
   fifo_vline_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vline_ev && !wr) |=> empty);
endmodule

// File: rtl/seq_scanline_irq.sv
module seq_scanline_irq
   import seq_pkg::*;
#(
   parameter int LINE_CYC     = 488,
   parameter int LEAD_CYC     = 148,
   parameter int LAG_CYC      = 68,
   parameter int NTSC_LINES   = 262,
   parameter int NTSC_VIS     = 224,
   parameter int PAL_LINES    = 313,
   parameter int PAL_VIS      = 224,
   parameter int PAL_TALL_VIS = 240,
   parameter bit TALL_EN      = 1'b1,
   parameter int HINT_W       = 8,
   parameter int FIFO_W       = 6,
   parameter int FIFO_DRAIN   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_tick,
   input  logic              pal_sel,
   input  logic              tall_sel,
   input  logic [HINT_W-1:0] hint_reload,
   input  logic              hint_en,
   input  logic              vint_en,
   input  logic              fifo_wr,
   input  logic              ack_hint,
   input  logic              ack_vint,
   output logic [7:0]        pend_bits,
   output logic [15:0]       status_word,
   output logic              irq_lvl4,
   output logic              irq_lvl6
);
   localparam int PB_H  = 4;
   localparam int PB_V  = 5;
   localparam int SB_VB = 3;
   localparam int SB_VF = 7;
   localparam int SB_FE = 9;

   evt_t evt;
   logic pend_h, pend_v, vblank, vflag, fifo_empty;

   seq_frame_timer #(
      .LINE_CYC(LINE_CYC), .LEAD_CYC(LEAD_CYC), .LAG_CYC(LAG_CYC),
      .NTSC_LINES(NTSC_LINES), .NTSC_VIS(NTSC_VIS),
      .PAL_LINES(PAL_LINES), .PAL_VIS(PAL_VIS), .PAL_TALL_VIS(PAL_TALL_VIS),
      .TALL_EN(TALL_EN)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .tick(cyc_tick),
      .pal_sel(pal_sel), .tall_sel(tall_sel), .evt(evt)
   );

   seq_hint_ctr #(.CNT_W(HINT_W)) i_hint (
      .clk(clk), .rst_n(rst_n), .frame_ev(evt.frame),
      .line_ev(evt.vis || evt.vline), .reload(hint_reload),
      .ack(ack_hint), .pend(pend_h)
   );

   seq_fifo_flag #(.CNT_W(FIFO_W), .DRAIN(FIFO_DRAIN)) i_fifo (
      .clk(clk), .rst_n(rst_n), .line_ev(evt.vis), .vline_ev(evt.vline),
      .wr(fifo_wr), .empty(fifo_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vblank <= 1'b0;
         vflag  <= 1'b0;
         pend_v <= 1'b0;
      end else begin
         if (evt.frame)      vblank <= 1'b0;
         else if (evt.vline) vblank <= 1'b1;
         if (evt.frame)      vflag  <= 1'b0;
         else if (evt.fire)  vflag  <= 1'b1;
         pend_v <= evt.vline || (pend_v && !ack_vint);
      end
   end

   always_comb begin
      pend_bits          = '0;
      pend_bits[PB_H]    = pend_h;
      pend_bits[PB_V]    = pend_v;
      status_word        = '0;
      status_word[SB_VB] = vblank;
      status_word[SB_VF] = vflag;
      status_word[SB_FE] = fifo_empty;
      irq_lvl4           = pend_h && hint_en;
      irq_lvl6           = pend_v && vflag && vint_en;
   end

   // R6
   vflag_after_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_word[SB_VF]) |-> status_word[SB_VB]);

   // R5
   vline_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.vline |=> (pend_bits[PB_V] && status_word[SB_VB]));

   // R2
   frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.frame |=> (!status_word[SB_VB] && !status_word[SB_VF]));
endmodule

// File: tb/test_seq_scanline_irq.sv
module test_seq_scanline_irq;
   localparam int LINE  = 20;
   localparam int LEAD  = 4;
   localparam int LAG   = 3;
   localparam int NL    = 12;
   localparam int NV    = 8;
   localparam int PL    = 15;
   localparam int PV    = 8;
   localparam int PTV   = 10;
   localparam int FW    = 4;
   localparam int DRAIN = 12;
   localparam int FMAX  = (1 << FW) - 1;

   logic       clk = 1'b0;
   logic       rst_n, cyc_tick, pal_sel, tall_sel, hint_en, vint_en;
   logic       fifo_wr, ack_hint, ack_vint;
   logic [7:0] hint_reload, pend_bits;
   logic [15:0] status_word;
   logic       irq_lvl4, irq_lvl6;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   seq_scanline_irq #(
      .LINE_CYC(LINE), .LEAD_CYC(LEAD), .LAG_CYC(LAG),
      .NTSC_LINES(NL), .NTSC_VIS(NV), .PAL_LINES(PL), .PAL_VIS(PV),
      .PAL_TALL_VIS(PTV), .TALL_EN(1'b1), .HINT_W(8), .FIFO_W(FW), .FIFO_DRAIN(DRAIN)
   ) i_seq_scanline_irq (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .pal_sel(pal_sel),
      .tall_sel(tall_sel), .hint_reload(hint_reload), .hint_en(hint_en),
      .vint_en(vint_en), .fifo_wr(fifo_wr), .ack_hint(ack_hint), .ack_vint(ack_vint),
      .pend_bits(pend_bits), .status_word(status_word),
      .irq_lvl4(irq_lvl4), .irq_lvl6(irq_lvl6)
   );

   function automatic int vis_of(bit p, bit t);
      return p ? (t ? PTV : PV) : NV;
   endfunction

   function automatic int frame_len(bit p);
      return (p ? PL : NL) * LINE;
   endfunction

   // reference model: position in frame drives all events
   int e, m_hint, m_fifo;
   bit m_pal, m_tall, m_empty, m_vb, m_vf, m_ph, m_pv;

   always @(posedge clk) begin : model
      bit fs, vv, vl, fi, sh;
      int vis;
      if (!rst_n) begin
         e = 0; m_pal = pal_sel; m_tall = tall_sel; m_hint = hint_reload;
         m_fifo = 0; m_empty = 1; m_vb = 0; m_vf = 0; m_ph = 0; m_pv = 0;
      end else begin
         fs = 0; vv = 0; vl = 0; fi = 0; sh = 0;
         vis = vis_of(m_pal, m_tall);
         if (cyc_tick) begin
            e++;
            if (e == frame_len(m_pal)) begin e = 0; fs = 1; end
            else if (e >= LEAD && e < LEAD + vis*LINE && (e - LEAD) % LINE == 0) vv = 1;
            else if (e == LEAD + vis*LINE) vl = 1;
            else if (e == LEAD + vis*LINE + LAG) fi = 1;
         end
         if (fs) begin
            m_pal = pal_sel; m_tall = tall_sel; m_vb = 0; m_vf = 0; m_hint = hint_reload;
         end
         if (vv || vl) begin
            if (m_hint == 0) begin m_hint = hint_reload; sh = 1; end
            else m_hint--;
         end
         if (vv) begin
            if (m_fifo <= DRAIN) begin m_fifo = 0; m_empty = 1; end
            else m_fifo -= DRAIN;
         end
         if (vl) begin m_fifo = 0; m_empty = 1; m_vb = 1; end
         if (fi) m_vf = 1;
         if (fifo_wr) begin
            if (m_fifo < FMAX) m_fifo++;
            m_empty = 0;
         end
         m_ph = sh | (m_ph & !ack_hint);
         m_pv = vl | (m_pv & !ack_vint);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1 R3 R11 pending bit 4", pend_bits[4], m_ph);
      chk("R5 R11 pending bit 5", pend_bits[5], m_pv);
      chk("R4 irq_lvl4", irq_lvl4, m_ph & hint_en);
      chk("R2 R5 R7 R12 vblank bit 3", status_word[3], m_vb);
      chk("R2 R6 vertical flag bit 7", status_word[7], m_vf);
      chk("R6 irq_lvl6", irq_lvl6, m_pv & m_vf & vint_en);
      chk("R8 R9 R10 fifo empty bit 9", status_word[9], m_empty);
      chk("R13 unused bits", {pend_bits & 8'hCF, status_word & 16'hFD77}, 0);
   endtask

   task automatic step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic rand_inputs(input int tick_pct, input int wr_div);
      cyc_tick = ($urandom % 100) < tick_pct;
      fifo_wr  = ($urandom % wr_div) == 0;
      ack_hint = ($urandom % 16) == 0;
      ack_vint = ($urandom % 16) == 0;
      if (($urandom % 64) == 0) pal_sel = ~pal_sel;
      if (($urandom % 64) == 0) tall_sel = ~tall_sel;
      if (($urandom % 32) == 0) hint_reload = 8'($urandom % 6);
      if (($urandom % 128) == 0) hint_en = ~hint_en;
      if (($urandom % 128) == 0) vint_en = ~vint_en;
   endtask

   task automatic reset_check();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R13 reset pend_bits", pend_bits, 0);
      chk("R13 reset status_word", status_word, 16'h0200);
      chk("R13 reset irq_lvl4", irq_lvl4, 0);
      chk("R13 reset irq_lvl6", irq_lvl6, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; cyc_tick = 1'b0; pal_sel = 1'b0; tall_sel = 1'b0;
      hint_reload = 8'd0; hint_en = 1'b1; vint_en = 1'b1;
      fifo_wr = 1'b0; ack_hint = 1'b0; ack_vint = 1'b0;
      @(negedge clk);
      reset_check();
      // directed: underflow every line, full-rate ticks, two NTSC frames
      cyc_tick = 1'b1;
      for (int i = 0; i < 2*NL*LINE; i++) step();
      // directed: saturating write burst with ticks held off
      cyc_tick = 1'b0; fifo_wr = 1'b1;
      for (int i = 0; i < 20; i++) step();
      fifo_wr = 1'b0; cyc_tick = 1'b1;
      for (int i = 0; i < 3*LINE; i++) step();
      // directed: 50 Hz tall mode, reload 2, acknowledges every 7th cycle
      pal_sel = 1'b1; tall_sel = 1'b1; hint_reload = 8'd2;
      for (int i = 0; i < 3*PL*LINE; i++) begin
         step();
         ack_hint = (i % 7) == 0;
         ack_vint = (i % 7) == 3;
      end
      ack_hint = 1'b0; ack_vint = 1'b0;
      // random mix
      for (int i = 0; i < 6000; i++) begin
         step();
         rand_inputs(75, 8);
      end
      cyc_tick = 1'b0; fifo_wr = 1'b0; ack_hint = 1'b0; ack_vint = 1'b0;
      @(negedge clk);
      reset_check();
      for (int i = 0; i < 2000; i++) begin
         step();
         rand_inputs(90, 4);
      end
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule